// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control finite-state machine of a non-pipelined processor that finishes one instruction before it starts the next. Each instruction moves through fetch, operand read, execute, an optional memory phase and an optional writeback phase. In every state the sequencer drives the datapath strobes: instruction-register load, register-file read enable and read-port select, ALU enable, memory read request, memory write enable, register write enable and writeback-source select. The datapath, the ALU and the memory lie outside the block.

The register file has a single read port. An instruction with two source registers therefore reads them in two consecutive states. Memory traffic uses a request/ready handshake. The sequencer raises a request (`mem_rd_req` for reads, `mem_we` for writes) and waits for as many cycles as `mem_ready` stays low. It moves on only in a cycle where `mem_ready` is high, so the memory applies back-pressure simply by holding `mem_ready` low. The instruction class comes from an external decoder. The sequencer samples it only in the cycle the fetch completes and holds it until the instruction retires.

Class encoding on `insn_class`: 0 is a register-register ALU operation, 1 is an ALU operation with an immediate, 2 is a load, 3 is a store, and every other code is illegal.

Top module: `mcs_ctrl_seq`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, every output is 0. The first cycle after it falls is a fetch cycle, and this holds even if reset arrived in the middle of an instruction.
- R2: The fetch state drives `mem_rd_req` high and holds for as long as `mem_ready` is low. In the cycle `mem_ready` is high, `ir_we` is high and `insn_class` is sampled. `insn_class` has no effect in any other cycle.
- R3: Class 0 reads the first source (`rf_rd_en`=1, `rf_rd_sel`=0) and then the second source (`rf_rd_en`=1, `rf_rd_sel`=1). It then spends one cycle with `alu_en` and one cycle with `rf_we`, for 5 cycles in total when the fetch has no wait.
- R4: Class 1 makes a single source read with `rf_rd_sel`=0, then one cycle of `alu_en` and one of `rf_we`, for 4 cycles in total when the fetch has no wait.
- R5: Class 2 makes a single source read and an `alu_en` cycle for the address. It then enters an issue state that raises `mem_rd_req` for exactly one cycle, followed by a wait state.
- R6: The load wait state drives no strobe. It repeats for every cycle `mem_ready` is low and is left in the first cycle `mem_ready` is high.
- R7: After the load wait state comes one writeback cycle with `rf_we`=1 and `wb_from_mem`=1. `rf_we` is never high for two cycles in a row.
- R8: Class 3 reads two sources, spends one cycle with `alu_en`, and then holds `mem_we` high in its memory state until a cycle with `mem_ready` high. After that cycle it returns to fetch. A store takes 5 cycles when neither the fetch nor the memory waits.
- R9: `mem_we` is high only in the memory state of a store. `mem_we`, `rf_we`, `mem_rd_req` and `illegal` are never high together.
- R10: An illegal class (4 to 7) makes `illegal` high for exactly one cycle, with no read, ALU, register or memory strobe, and the next cycle is a fetch.
- R11: `mem_ready` has no effect in the operand-read, execute, issue, writeback and illegal states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_class | input | CLS_W (3) | Decoded instruction class, sampled when a fetch completes |
| mem_ready | input | 1 | Memory ready: completes a fetch, load or store |
| ir_we | output | 1 | Load the instruction register |
| rf_rd_en | output | 1 | Register-file read port active |
| rf_rd_sel | output | 1 | Read-port source select: 0 first source, 1 second source |
| alu_en | output | 1 | ALU executes this cycle |
| mem_rd_req | output | 1 | Memory read request (fetch or load issue) |
| mem_we | output | 1 | Memory write enable |
| rf_we | output | 1 | Register-file write enable |
| wb_from_mem | output | 1 | Writeback data comes from memory rather than the ALU |
| illegal | output | 1 | One-cycle illegal-instruction flag |

## Verification
The bench stretches `mem_ready` low for varying lengths in fetch, in the load wait and in the store memory state. A design that left a wait state early would show its next strobes one cycle too soon, and one that ignored the handshake would drop `mem_we` before the write completed. It holds `mem_ready` high in states that should ignore it and puts an illegal class code on `insn_class` in every cycle except the fetch-completion cycle. A sequencer that sampled the class late, or that advanced on a stray ready, would therefore take the wrong path or skip a state. It also resets in the middle of a load wait, runs both illegal codes at the ends of the range, and checks the 4-cycle and 5-cycle lengths, which catch a missing or spurious second operand read.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [3:0] {
    ST_FETCH     = 4'd0,
    ST_RD_A      = 4'd1,
    ST_RD_B      = 4'd2,
    ST_EXEC      = 4'd3,
    ST_MEM_ISSUE = 4'd4,
    ST_MEM_WAIT  = 4'd5,
    ST_MEM_WR    = 4'd6,
    ST_WB        = 4'd7,
    ST_TRAP      = 4'd8
  } seq_state_t;

  localparam int CLS_ALU_RR  = 0;
  localparam int CLS_ALU_IMM = 1;
  localparam int CLS_LOAD    = 2;
  localparam int CLS_STORE   = 3;

  typedef struct packed {
    logic legal;
    logic two_src;
    logic is_load;
    logic is_store;
  } cls_info_t;

  typedef struct packed {
    logic ir_we;
    logic rf_rd_en;
    logic rf_rd_sel;
    logic alu_en;
    logic mem_rd_req;
    logic mem_we;
    logic rf_we;
    logic wb_from_mem;
    logic illegal;
  } ctrl_t;

endpackage

// File: rtl/mcs_class_dec.sv
module mcs_class_dec
  import mcs_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input  logic [CLS_W-1:0] cls,
  output cls_info_t        info
);

  localparam logic [CLS_W-1:0] C_RR  = CLS_W'(CLS_ALU_RR);
  localparam logic [CLS_W-1:0] C_IMM = CLS_W'(CLS_ALU_IMM);
  localparam logic [CLS_W-1:0] C_LD  = CLS_W'(CLS_LOAD);
  localparam logic [CLS_W-1:0] C_ST  = CLS_W'(CLS_STORE);

  logic hit_rr, hit_imm, hit_ld, hit_st;

  always_comb begin
    hit_rr  = (cls == C_RR);
    hit_imm = (cls == C_IMM);
    hit_ld  = (cls == C_LD);
    hit_st  = (cls == C_ST);
    info.legal    = hit_rr | hit_imm | hit_ld | hit_st;
    info.two_src  = hit_rr | hit_st;
    info.is_load  = hit_ld;
    info.is_store = hit_st;
  end

endmodule

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
(
  input  seq_state_t state,
  input  logic       mem_ready,
  input  cls_info_t  info,
  output seq_state_t nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (state)
      ST_FETCH: begin
        if (!mem_ready)      nxt = ST_FETCH;
        else if (info.legal) nxt = ST_RD_A;
        else                 nxt = ST_TRAP;
      end
      ST_RD_A:      nxt = info.two_src ? ST_RD_B : ST_EXEC;
      ST_RD_B:      nxt = ST_EXEC;
      ST_EXEC: begin
        if (info.is_load)       nxt = ST_MEM_ISSUE;
        else if (info.is_store) nxt = ST_MEM_WR;
        else                    nxt = ST_WB;
      end
      ST_MEM_ISSUE: nxt = ST_MEM_WAIT;
      ST_MEM_WAIT:  nxt = mem_ready ? ST_WB : ST_MEM_WAIT;
      ST_MEM_WR:    nxt = mem_ready ? ST_FETCH : ST_MEM_WR;
      ST_WB:        nxt = ST_FETCH;
      ST_TRAP:      nxt = ST_FETCH;
      default:      nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcs_out_dec.sv
module mcs_out_dec
  import mcs_pkg::*;
(
  input  logic       rst,
  input  seq_state_t state,
  input  logic       mem_ready,
  input  cls_info_t  info,
  output ctrl_t      ctl
);

  ctrl_t raw;

  always_comb begin
    raw = '0;
    unique case (state)
      ST_FETCH: begin
        raw.mem_rd_req = 1'b1;
        raw.ir_we      = mem_ready;
      end
      ST_RD_A: raw.rf_rd_en = 1'b1;
      ST_RD_B: begin
        raw.rf_rd_en  = 1'b1;
        raw.rf_rd_sel = 1'b1;
      end
      ST_EXEC:      raw.alu_en     = 1'b1;
      ST_MEM_ISSUE: raw.mem_rd_req = 1'b1;
      ST_MEM_WAIT:  raw            = '0;
      ST_MEM_WR:    raw.mem_we     = info.is_store;
      ST_WB: begin
        raw.rf_we       = 1'b1;
        raw.wb_from_mem = info.is_load;
      end
      ST_TRAP: raw.illegal = 1'b1;
      default: raw = '0;
    endcase
    ctl = rst ? '0 : raw;
  end

endmodule

// File: rtl/mcs_ctrl_seq.sv
module mcs_ctrl_seq
  import mcs_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CLS_W-1:0] insn_class,
  input  logic             mem_ready,
  output logic             ir_we,
  output logic             rf_rd_en,
  output logic             rf_rd_sel,
  output logic             alu_en,
  output logic             mem_rd_req,
  output logic             mem_we,
  output logic             rf_we,
  output logic             wb_from_mem,
  output logic             illegal
);

  seq_state_t       state_q, state_d;
  logic [CLS_W-1:0] cls_q;
  logic [CLS_W-1:0] cls_eff;
  logic             fetch_done;
  cls_info_t        info;
  ctrl_t            ctl;

  // The class is live on the port only while the fetch completes.
  assign fetch_done = (state_q == ST_FETCH) && mem_ready;
  assign cls_eff    = (state_q == ST_FETCH) ? insn_class : cls_q;

  mcs_class_dec #(.CLS_W(CLS_W)) u_dec (
    .cls  (cls_eff),
    .info (info)
  );

  mcs_next_state u_nxt (
    .state     (state_q),
    .mem_ready (mem_ready),
    .info      (info),
    .nxt       (state_d)
  );

  mcs_out_dec u_out (
    .rst       (rst),
    .state     (state_q),
    .mem_ready (mem_ready),
    .info      (info),
    .ctl       (ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      cls_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fetch_done) cls_q <= insn_class;
    end
  end

  assign ir_we       = ctl.ir_we;
  assign rf_rd_en    = ctl.rf_rd_en;
  assign rf_rd_sel   = ctl.rf_rd_sel;
  assign alu_en      = ctl.alu_en;
  assign mem_rd_req  = ctl.mem_rd_req;
  assign mem_we      = ctl.mem_we;
  assign rf_we       = ctl.rf_we;
  assign wb_from_mem = ctl.wb_from_mem;
  assign illegal     = ctl.illegal;

endmodule

// File: rtl/mcs_ctrl_chk.sv
module mcs_ctrl_chk
  import mcs_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input logic             clk,
  input logic             rst,
  input seq_state_t       state_q,
  input logic [CLS_W-1:0] cls_q,
  input logic             mem_ready,
  input logic             ir_we,
  input logic             rf_rd_en,
  input logic             rf_rd_sel,
  input logic             mem_rd_req,
  input logic             mem_we,
  input logic             rf_we,
  input logic             illegal
);

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |-> !(ir_we || rf_rd_en || mem_rd_req || mem_we || rf_we || illegal)); // R1

  AST_RST_TO_FETCH: assert property (@(posedge clk)
    rst |=> (state_q == ST_FETCH)); // R1

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH && !mem_ready) |=> (state_q == ST_FETCH)); // R2

  AST_SECOND_READ_ORDER: assert property (@(posedge clk) disable iff (rst)
    (rf_rd_en && rf_rd_sel) |-> $past(rf_rd_en && !rf_rd_sel)); // R3

  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM_ISSUE) |=> (!mem_rd_req && state_q == ST_MEM_WAIT)); // R5

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM_WAIT && !mem_ready) |=> (state_q == ST_MEM_WAIT)); // R6

  AST_RF_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we); // R7

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ready) |=> mem_we); // R8

  AST_WE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (cls_q == CLS_W'(CLS_STORE))); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, rf_we, mem_rd_req, illegal})); // R9

  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (!illegal && state_q == ST_FETCH)); // R10

endmodule

bind mcs_ctrl_seq mcs_ctrl_chk #(.CLS_W(CLS_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .state_q    (state_q),
  .cls_q      (cls_q),
  .mem_ready  (mem_ready),
  .ir_we      (ir_we),
  .rf_rd_en   (rf_rd_en),
  .rf_rd_sel  (rf_rd_sel),
  .mem_rd_req (mem_rd_req),
  .mem_we     (mem_we),
  .rf_we      (rf_we),
  .illegal    (illegal)
);

// File: tb/mcs_ctrl_seq_tb_top.sv
module mcs_ctrl_seq_tb_top;

  localparam logic [8:0] O_IRWE = 9'h100;
  localparam logic [8:0] O_RDEN = 9'h080;
  localparam logic [8:0] O_SEL  = 9'h040;
  localparam logic [8:0] O_ALU  = 9'h020;
  localparam logic [8:0] O_REQ  = 9'h010;
  localparam logic [8:0] O_MWE  = 9'h008;
  localparam logic [8:0] O_RFWE = 9'h004;
  localparam logic [8:0] O_WBM  = 9'h002;
  localparam logic [8:0] O_ILL  = 9'h001;
  localparam logic [2:0] JUNK   = 3'd5;

  typedef struct {
    logic       rdy;
    logic [2:0] cls;
    logic [8:0] exp;
    string      tag;
  } step_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] insn_class = JUNK;
  logic       mem_ready = 1'b0;
  logic       ir_we, rf_rd_en, rf_rd_sel, alu_en, mem_rd_req;
  logic       mem_we, rf_we, wb_from_mem, illegal;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  step_t q[$];

  always #2 clk = ~clk;

  mcs_ctrl_seq dut_i (
    .clk(clk), .rst(rst), .insn_class(insn_class), .mem_ready(mem_ready),
    .ir_we(ir_we), .rf_rd_en(rf_rd_en), .rf_rd_sel(rf_rd_sel), .alu_en(alu_en),
    .mem_rd_req(mem_rd_req), .mem_we(mem_we), .rf_we(rf_we),
    .wb_from_mem(wb_from_mem), .illegal(illegal)
  );

  function automatic logic [8:0] outs();
    return {ir_we, rf_rd_en, rf_rd_sel, alu_en, mem_rd_req,
            mem_we, rf_we, wb_from_mem, illegal};
  endfunction

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: outputs act=%b exp=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input logic r, input logic [2:0] c, input logic [8:0] e, input string t);
    step_t s;
    s.rdy = r; s.cls = c; s.exp = e; s.tag = t;
    q.push_back(s);
  endtask

  // Reference: per-cycle expected strobes of one instruction.
  task automatic add_instr(input logic [2:0] c, input int fw, input int dw);
    for (int i = 0; i < fw; i++) push(1'b0, JUNK, O_REQ, "R2");
    push(1'b1, c, O_REQ | O_IRWE, "R2");
    case (c)
      3'd0: begin
        push(1'b1, JUNK, O_RDEN, "R3/R11");
        push(1'b1, JUNK, O_RDEN | O_SEL, "R3/R11");
        push(1'b1, JUNK, O_ALU, "R3/R11");
        push(1'b1, JUNK, O_RFWE, "R3/R11");
      end
      3'd1: begin
        push(1'b1, JUNK, O_RDEN, "R4/R11");
        push(1'b1, JUNK, O_ALU, "R4/R11");
        push(1'b1, JUNK, O_RFWE, "R4/R11");
      end
      3'd2: begin
        push(1'b1, JUNK, O_RDEN, "R5/R11");
        push(1'b1, JUNK, O_ALU, "R5/R11");
        push(1'b1, JUNK, O_REQ, "R5/R11");
        for (int i = 0; i < dw; i++) push(1'b0, JUNK, 9'h000, "R6");
        push(1'b1, JUNK, 9'h000, "R6");
        push(1'b1, JUNK, O_RFWE | O_WBM, "R7/R11");
      end
      3'd3: begin
        push(1'b1, JUNK, O_RDEN, "R8/R11");
        push(1'b1, JUNK, O_RDEN | O_SEL, "R8/R11");
        push(1'b1, JUNK, O_ALU, "R8/R11");
        for (int i = 0; i < dw; i++) push(1'b0, JUNK, O_MWE, "R8/R9");
        push(1'b1, JUNK, O_MWE, "R8/R9");
      end
      default: push(1'b1, JUNK, O_ILL, "R10/R11");
    endcase
  endtask

  task automatic step();
    step_t s;
    @(negedge clk);
    s = q.pop_front();
    rst = 1'b0; mem_ready = s.rdy; insn_class = s.cls;
    #1 check(outs(), s.exp, s.tag);
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1'b1; mem_ready = 1'b1; insn_class = 3'd3;
      #1 check(outs(), 9'h000, "R1");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    do_reset(3);
    // zero-wait baselines: R3 5 cycles, R4 4 cycles, R8 5 cycles
    add_instr(3'd0, 0, 0); drain();
    add_instr(3'd1, 0, 0); drain();
    add_instr(3'd2, 0, 0); drain();
    add_instr(3'd3, 0, 0); drain();
    // illegal codes at both ends of the range (R10)
    add_instr(3'd4, 0, 0); drain();
    add_instr(3'd7, 2, 0); drain();
    // stretched handshakes (R2, R6, R8)
    add_instr(3'd0, 3, 0); drain();
    add_instr(3'd2, 1, 4); drain();
    add_instr(3'd3, 2, 5); drain();
    add_instr(3'd1, 1, 0); drain();
    // reset in the middle of a load wait (R1)
    add_instr(3'd2, 0, 6);
    for (int i = 0; i < 6; i++) step();
    q.delete();
    do_reset(2);
    add_instr(3'd1, 0, 0); drain();
    // sweep all classes against wait lengths
    for (int w = 0; w < 4; w++)
      for (int c = 0; c < 8; c++) begin
        add_instr(3'(c), (c + w) % 3, w * 2);
        drain();
      end
    finish_run();
  end

endmodule